// File: doc/BRIEF.md
# Component Register File with Decoder Commit

This block is the memory-mapped register file of a cache/memory-protocol component. A host reaches it over a simple word bus: a word address, 32-bit write data, a write enable, a read strobe and a flag that marks an 8-byte access. Read data comes back one cycle after the read strobe. Every write is merged with the stored word through a write mask that belongs to that word, so read-only bits cannot be changed.

The register space holds three groups. The first is a capability header array whose length follows the `KIND` parameter. The second is a RAS error group: status, mask, severity and capability registers. The third is a single address-range decoder register set. Its control word runs a small commit state machine with two states. `DEC_IDLE` reports the decoder as not committed. `DEC_LIVE` reports it as committed. The COMMIT transition goes from `DEC_IDLE` to `DEC_LIVE` on a control write with the commit bit set. The UNCOMMIT transition goes from `DEC_LIVE` to `DEC_IDLE` on a control write with the commit bit clear. Any other cycle holds the current state.

Word map:

| Words | Content |
|---|---|
| 0 | Top-level header |
| 1 | RAS header |
| 2 | Link header |
| 3 | Decoder header |
| 4 | Extended-security header |
| 5 | Snoop header |
| 16–21 | RAS group: uncorrectable status, uncorrectable mask, uncorrectable severity, correctable status, correctable mask, capability/control |
| 48 | Decoder capability |
| 49 | Decoder global control |
| 52 | Base low |
| 53 | Base high |
| 54 | Size low |
| 55 | Size high |
| 56 | Control |
| 57 | Target list low |
| 58 | Target list high |

Top module: `comp_regfile`

## Requirements
- R1: The header at word 0 reads with ID 1 in bits 15:0, version 1 in bits 19:16, cache-mem version 1 in bits 23:20 and the capability count in bits 31:24. The count follows the `KIND` parameter: 2 for a downstream port (`KIND` 0) and a plain device (`KIND` 1), 3 for an upstream port (`KIND` 2) and a memory device (`KIND` 3), and 5 for a root port (`KIND` 4).
- R2: Header word k, for 1 ≤ k ≤ count, reads as ID in bits 15:0, version in bits 19:16 and the group's byte offset in bits 31:20. The values are RAS 2/2/0x040, link 4/2/0x080, decoder 5/1/0x0C0, extended security 6/1/0x100 and snoop 8/1/0x140. Header words above the count read zero.
- R3: A 4-byte write stores (wdata AND mask) OR (old AND NOT mask), using the mask of the addressed word.
- R4: The reset and mask values of the RAS group are as follows. The uncorrectable mask and severity reset to 0x1CFFF with mask 0x1CFFF. The uncorrectable status resets to 0 with mask 0x1CFFF. The correctable status resets to 0 with mask 0x7F. The correctable mask resets to 0x7F with mask 0x7F. The capability/control word resets to 0x200 and is read-only.
- R5: The decoder capability word reads 0x310 and is read-only: decoder-count code 0 in bits 3:0, target count 1 in bits 7:4, 256-byte interleave in bit 8, 4 KB interleave in bit 9 and no poison in bit 10. The global control word resets to 0 with mask 0x3.
- R6: Base low and size low are writable only in bits 31:28. Base high and size high are fully writable. The control word mask is 0x13FF.
- R7: Target list low has mask 0xF0000000 for device kinds (`KIND` 1 and 3) and 0xFFFFFFFF for port kinds.
- R8: A control write with the commit bit (bit 9) set reads back with the committed bit (bit 10) at 1 and the error bit (bit 11) at 0. A control write with bit 9 clear reads back with both bits at 0.
- R9: An access with `wide` high is an 8-byte access. As a write it changes nothing. As a read it returns zero.
- R10: When the count is below 3, the decoder words read zero and ignore writes. Unmapped words read zero.
- R11: `rdata` is registered. It shows the addressed word one cycle after `rd_en` and zero after a cycle without a read.
- R12: A synchronous active-high `rst` returns every register, and the commit state, to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read strobe |
| wide | input | 1 | Marks an 8-byte access |
| rdata | output | 32 | Registered read data |

## Verification
On every cycle, the assertions check the read-path timing: zero after an idle cycle, and zero after an 8-byte read. They also check that the commit state follows each control write, that the fixed bits of base low survive writes, and that the RAS capability word never moves. Reset values, the per-word masks, the header arrays for each component kind and the absence of the decoder for small kinds can only be shown by the bench. It reads these back through the bus on three instances of the block, each built for a different kind.

// File: rtl/comp_reg_pkg.sv
package comp_reg_pkg;

    typedef enum logic [2:0] {
        CK_DSP    = 3'd0,
        CK_DEV    = 3'd1,
        CK_USP    = 3'd2,
        CK_MEMDEV = 3'd3,
        CK_ROOT   = 3'd4
    } comp_kind_e;

    typedef enum logic [0:0] {
        DEC_IDLE = 1'b0,
        DEC_LIVE = 1'b1
    } dec_state_e;

    localparam int HDR_WORDS = 6;
    localparam int RAS_BASE  = 16;
    localparam int RAS_WORDS = 6;
    localparam int HDM_BASE  = 48;
    localparam int HDM_WORDS = 11;
    localparam int HDM_CTRL  = 8;
    localparam int COMMIT_B  = 9;
    localparam int DONE_B    = 10;

    function automatic int caps_of(comp_kind_e k);
        case (k)
            CK_DSP, CK_DEV:     return 2;
            CK_USP, CK_MEMDEV:  return 3;
            default:            return 5;
        endcase
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old_v, logic [31:0] new_v,
                                          logic [31:0] msk);
        return (new_v & msk) | (old_v & ~msk);
    endfunction

    function automatic logic [31:0] cap_hdr(int k);
        logic [15:0] id;
        logic [3:0]  ver;
        logic [11:0] ptr;
        case (k)
            1:       begin id = 16'd2; ver = 4'd2; ptr = 12'h040; end
            2:       begin id = 16'd4; ver = 4'd2; ptr = 12'h080; end
            3:       begin id = 16'd5; ver = 4'd1; ptr = 12'h0C0; end
            4:       begin id = 16'd6; ver = 4'd1; ptr = 12'h100; end
            default: begin id = 16'd8; ver = 4'd1; ptr = 12'h140; end
        endcase
        return {ptr, ver, id};
    endfunction

    function automatic logic [31:0] ras_rst(int i);
        case (i)
            1, 2:    return 32'h0001_CFFF;
            4:       return 32'h0000_007F;
            5:       return 32'h0000_0200;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] ras_msk(int i);
        case (i)
            0, 1, 2: return 32'h0001_CFFF;
            3, 4:    return 32'h0000_007F;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] hdm_msk(int i, logic dev_like);
        case (i)
            1:          return 32'h0000_0003;
            4, 6:       return 32'hF000_0000;
            5, 7, 10:   return 32'hFFFF_FFFF;
            8:          return 32'h0000_13FF;
            9:          return dev_like ? 32'hF000_0000 : 32'hFFFF_FFFF;
            default:    return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/comp_cap_hdr.sv
module comp_cap_hdr
    import comp_reg_pkg::*;
#(
    parameter comp_kind_e KIND   = CK_MEMDEV,
    parameter int         ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [31:0]       rd
);
    localparam int CAPS = caps_of(KIND);

    always_comb begin
        int unsigned a;
        a  = int'(addr);
        rd = '0;
        if (a == 0) begin
            rd = {8'(CAPS), 4'd1, 4'd1, 16'd1};
        end else if (a < HDR_WORDS && a <= CAPS) begin
            rd = cap_hdr(int'(a));
        end
    end
endmodule

// File: rtl/comp_ras_regs.sv
module comp_ras_regs
    import comp_reg_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd
);
    logic [31:0] regs [RAS_WORDS];
    logic        hit;
    int unsigned idx;

    always_comb begin
        idx = int'(addr) - RAS_BASE;
        hit = (int'(addr) >= RAS_BASE) && (int'(addr) < RAS_BASE + RAS_WORDS);
        rd  = hit ? regs[idx] : '0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < RAS_WORDS; i++) begin
            if (rst)
                regs[i] <= ras_rst(i);
            else if (wr && hit && idx == i)
                regs[i] <= merge(regs[i], wdata, ras_msk(i));
        end
    end

    // R4
    ras_capctl_ro_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(regs[5])) else $error("R4 RAS capability word moved");
endmodule

// File: rtl/comp_hdm_regs.sv
module comp_hdm_regs
    import comp_reg_pkg::*;
#(
    parameter comp_kind_e KIND   = CK_MEMDEV,
    parameter int         ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd
);
    localparam logic DEV_LIKE = (KIND == CK_DEV) || (KIND == CK_MEMDEV);

    logic [31:0] regs [HDM_WORDS];
    logic        hit, ctrl_wr, committed;
    int unsigned idx;
    dec_state_e  state_q, state_d;

    always_comb begin
        idx     = int'(addr) - HDM_BASE;
        hit     = (int'(addr) >= HDM_BASE) && (int'(addr) < HDM_BASE + HDM_WORDS);
        ctrl_wr = wr && hit && (idx == HDM_CTRL);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < HDM_WORDS; i++) begin
            if (rst)
                regs[i] <= (i == 0) ? 32'h0000_0310 : 32'h0;
            else if (wr && hit && idx == i)
                regs[i] <= merge(regs[i], wdata, hdm_msk(i, DEV_LIKE));
        end
    end

    // commit state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= DEC_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_IDLE: if (ctrl_wr && wdata[COMMIT_B])  state_d = DEC_LIVE;
            DEC_LIVE: if (ctrl_wr && !wdata[COMMIT_B]) state_d = DEC_IDLE;
        endcase
    end

    // outputs: committed flag and read mux (error bit always reads 0)
    always_comb begin
        committed = (state_q == DEC_LIVE);
        rd = '0;
        if (hit) begin
            rd = regs[idx];
            if (idx == HDM_CTRL) rd[DONE_B] = committed;
        end
    end

    // R8
    commit_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[COMMIT_B]) |=> committed) else $error("R8 commit lost");
    // R8
    uncommit_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wdata[COMMIT_B]) |=> !committed) else $error("R8 uncommit lost");
    // R6
    base_lo_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && hit && idx == 4) |=> regs[4][27:0] == $past(regs[4][27:0]))
        else $error("R6 base low fixed bits moved");
endmodule

// File: rtl/comp_regfile.sv
module comp_regfile
    import comp_reg_pkg::*;
#(
    parameter comp_kind_e KIND   = CK_MEMDEV,
    parameter int         ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              wide,
    output logic [31:0]       rdata
);
    localparam int CAPS = caps_of(KIND);

    logic        wr_ok;
    logic [31:0] hdr_rd, ras_rd, hdm_rd;

    assign wr_ok = wr_en && !wide;

    comp_cap_hdr #(.KIND(KIND), .ADDR_W(ADDR_W)) u_hdr (
        .addr(addr), .rd(hdr_rd));

    comp_ras_regs #(.ADDR_W(ADDR_W)) u_ras (
        .clk(clk), .rst(rst), .wr(wr_ok), .addr(addr), .wdata(wdata), .rd(ras_rd));

    generate
        if (CAPS >= 3) begin : g_hdm
            comp_hdm_regs #(.KIND(KIND), .ADDR_W(ADDR_W)) u_hdm (
                .clk(clk), .rst(rst), .wr(wr_ok), .addr(addr),
                .wdata(wdata), .rd(hdm_rd));
        end else begin : g_no_hdm
            assign hdm_rd = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                 rdata <= '0;
        else if (rd_en && !wide) rdata <= hdr_rd | ras_rd | hdm_rd;
        else                     rdata <= '0;
    end

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0) else $error("R11 rdata not zero when idle");
    // R9
    wide_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wide) |=> rdata == '0) else $error("R9 wide read not zero");
endmodule

// File: tb/test_comp_regfile.sv
module test_comp_regfile;
    import comp_reg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, wide = 1'b0;
    logic [31:0] rd_m, rd_r, rd_d;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    comp_regfile #(.KIND(CK_MEMDEV)) i_comp_regfile (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .wide(wide), .rdata(rd_m));
    comp_regfile #(.KIND(CK_ROOT)) i_comp_regfile_root (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .wide(wide), .rdata(rd_r));
    comp_regfile #(.KIND(CK_DSP)) i_comp_regfile_dsp (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .wide(wide), .rdata(rd_d));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic w8 = 1'b0);
        @(negedge clk);
        addr = 7'(a); wdata = d; wr_en = 1'b1; wide = w8;
        @(negedge clk);
        wr_en = 1'b0; wide = 1'b0;
    endtask

    task automatic rd(input int a, input logic w8 = 1'b0);
        @(negedge clk);
        addr = 7'(a); rd_en = 1'b1; wide = w8;
        @(negedge clk);
        rd_en = 1'b0; wide = 1'b0;
    endtask

    task automatic t_reset_state;
        rd(0);
        chk("R1 mem header", rd_m, 32'h0311_0001);
        chk("R1 root header", rd_r, 32'h0511_0001);
        chk("R1 dsp header", rd_d, 32'h0211_0001);
        @(negedge clk);
        chk("R11 idle zero", rd_m, 32'h0);
    endtask

    task automatic t_headers;
        rd(1); chk("R2 ras hdr", rd_m, 32'h0402_0002);
        rd(2); chk("R2 link hdr", rd_d, 32'h0802_0004);
        rd(3); chk("R2 hdm hdr", rd_m, 32'h0C01_0005);
        chk("R2 dsp no hdm hdr", rd_d, 32'h0);
        rd(4); chk("R2 extsec hdr", rd_r, 32'h1001_0006);
        chk("R2 mem no extsec", rd_m, 32'h0);
        rd(5); chk("R2 snoop hdr", rd_r, 32'h1401_0008);
    endtask

    task automatic t_ras;
        rd(17); chk("R4 unc mask rst", rd_m, 32'h0001_CFFF);
        rd(18); chk("R4 unc sev rst", rd_m, 32'h0001_CFFF);
        rd(20); chk("R4 cor mask rst", rd_m, 32'h0000_007F);
        rd(21); chk("R4 capctl rst", rd_m, 32'h0000_0200);
        wr(17, 32'h0);  rd(17); chk("R3 unc mask clear", rd_m, 32'h0);
        wr(17, 32'hFFFF_FFFF); rd(17); chk("R3 unc mask merge", rd_m, 32'h0001_CFFF);
        wr(19, 32'hFFFF_FF00); rd(19); chk("R4 cor status mask", rd_m, 32'h0000_0000);
        wr(21, 32'h0);  rd(21); chk("R4 capctl ro", rd_m, 32'h0000_0200);
    endtask

    task automatic t_hdm_fields;
        rd(48); chk("R5 hdm cap", rd_m, 32'h0000_0310);
        wr(48, 32'h0);  rd(48); chk("R5 hdm cap ro", rd_m, 32'h0000_0310);
        wr(49, 32'hFF); rd(49); chk("R5 global mask", rd_m, 32'h3);
        wr(52, 32'hFFFF_FFFF); rd(52); chk("R6 base lo", rd_m, 32'hF000_0000);
        wr(53, 32'hDEAD_BEEF); rd(53); chk("R6 base hi", rd_m, 32'hDEAD_BEEF);
        wr(54, 32'h1234_5678); rd(54); chk("R6 size lo", rd_m, 32'h1000_0000);
        wr(57, 32'hFFFF_FFFF); rd(57);
        chk("R7 tl lo device", rd_m, 32'hF000_0000);
        chk("R7 tl lo port", rd_r, 32'hFFFF_FFFF);
    endtask

    task automatic t_commit;
        wr(56, 32'hFFFF_FFFF); rd(56); chk("R8 commit", rd_m, 32'h0000_17FF);
        wr(56, 32'h0000_0005); rd(56); chk("R8 uncommit", rd_m, 32'h0000_0005);
        wr(56, 32'h0000_0C00); rd(56); chk("R8 status not writable", rd_m, 32'h0);
        wr(56, 32'h0000_0200); rd(56); chk("R8 commit again", rd_r, 32'h0000_0600);
    endtask

    task automatic t_wide;
        wr(18, 32'h0, 1'b1); rd(18); chk("R9 wide write ignored", rd_m, 32'h0001_CFFF);
        rd(0, 1'b1); chk("R9 wide read zero", rd_m, 32'h0);
    endtask

    task automatic t_absent;
        wr(53, 32'hFFFF_FFFF); rd(53); chk("R10 dsp hdm zero", rd_d, 32'h0);
        rd(100); chk("R10 unmapped zero", rd_r, 32'h0);
    endtask

    task automatic t_reset_mid;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(56); chk("R12 ctrl after reset", rd_m, 32'h0);
        rd(17); chk("R12 unc mask after reset", rd_m, 32'h0001_CFFF);
        rd(53); chk("R12 base hi after reset", rd_r, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state;
        t_headers;
        t_ras;
        t_hdm_fields;
        t_commit;
        t_wide;
        t_absent;
        t_reset_mid;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule